// File: doc/BRIEF.md
# Dual-bridge phase-shift PWM generator

This block drives the eight switches of an isolated converter built from two full bridges coupled by a transformer. Every switch toggles at a fixed half-period duty. Power flows according to the phase shift between the primary and the secondary square waves, and the sign of that shift sets the direction of power flow. Optional shifts between the two legs of each bridge support the extended, dual and triple shift schemes. A run-time dead time keeps the two switches of any leg from conducting together.

A single free-running counter sets the timing. Period, shifts, dead time and scheme are sampled, clamped and committed only at the end of a period, so no switching period mixes two settings. A once-per-period pulse marks count zero so that sampling and control updates can run at the PWM rate. A fault input blanks all gates at once and holds them off until the controller clears the fault explicitly.

Top module: `dab_pwm_gen`

## Requirements
- R1: The counter runs through P counts per period. `sync_pulse` is high for exactly one clock per period, in the same clock that the gates show count n=0. The following pulse comes P clocks later.
- R2: Let H = P/2 (rounded down) and d be the dead time. On the primary, with primary leg shift 0, gate[0] (Q1) and gate[3] (Q4) are on for n in [d,H). gate[1] (Q2) and gate[2] (Q3) are on for n in [H+d,P).
- R3: On the secondary, positions are taken as m = (n - s) mod P, where s is the signed outer shift. gate[4] (Q5) is on for m in [d,H) and gate[5] (Q6) is on for m in [H+d,P). A positive s delays the secondary and a negative s advances it.
- R4: The two switches of one leg (gate pairs 0/1, 2/3, 4/5, 6/7) are never on together. Both are off for d counts after each half-period edge of that leg.
- R5: `shift_mode` selects the scheme. 0 = single: no leg shifts. 1 = extended: Q3/Q4 leg delayed by `inner_pri`. 2 = dual: both second legs delayed by `inner_pri`. 3 = triple: the primary uses `inner_pri` and the secondary uses `inner_sec`. The delay is applied to the Q3/Q4 and Q7/Q8 legs, whose on windows are [H+d,P) for Q3/Q7 and [d,H) for Q4/Q8.
- R6: `period` sets P directly. Values below PRD_MIN (16) are raised to PRD_MIN. A period of 500 counts (200 kHz at 100 MHz) is supported.
- R7: Period, shifts, dead time and mode change on the outputs only at the start of a period. A change made mid-period leaves the rest of that period untouched.
- R8: The outer shift is clamped to magnitude P/4-1. Inner shifts are clamped to H. Dead time is clamped to H-1.
- R9: A high `fault_in` forces all gates low from the next clock. The fault stays latched after `fault_in` falls. A `fault_clr` pulse releases it only while `fault_in` is low. Switching then restarts at n=0 two clocks after the clear is sampled.
- R10: While `en` is low, all gates and `sync_pulse` are low. The first enabled clock starts at n=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Switching enable |
| period | input | CNT_W | Period in clock counts |
| outer_shift | input | CNT_W | Signed primary-to-secondary shift |
| inner_pri | input | CNT_W | Primary leg-to-leg shift |
| inner_sec | input | CNT_W | Secondary leg-to-leg shift (triple scheme) |
| shift_mode | input | 2 | Scheme select |
| dead_time | input | CNT_W | Dead time in counts |
| fault_in | input | 1 | Fault request |
| fault_clr | input | 1 | Fault release |
| gate | output | 8 | Gate commands Q1..Q8 on bits 0..7 |
| sync_pulse | output | 1 | Period-start event |

## Verification
The hardest case to reach is a settings change that lands in the middle of a period. Only the later part of that period shows whether the old values were kept. The stimulus locks onto `sync_pulse`, counts clocks into the period, and rewrites the shift and dead time at a known count. It then compares the remainder against the old settings and the next full period against the new ones. A second hard case is the fault release while the fault request is still high. The bench reaches it by raising clear and fault together and confirming the gates stay dark.

// File: rtl/dab_pwm_pkg.sv
package dab_pwm_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_EXT    = 2'd1,
    MODE_DUAL   = 2'd2,
    MODE_TRIPLE = 2'd3
  } shift_mode_e;

  localparam int NUM_LEGS  = 4;
  localparam int NUM_GATES = 2 * NUM_LEGS;
endpackage

// File: rtl/dab_timebase.sv
module dab_timebase
  import dab_pwm_pkg::*;
#(
  parameter int CNT_W   = 12,
  parameter int PRD_MIN = 16
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              run,
  input  logic [CNT_W-1:0]                  prd_in,
  input  logic signed [CNT_W-1:0]           outer_in,
  input  logic [CNT_W-1:0]                  inner_pri_in,
  input  logic [CNT_W-1:0]                  inner_sec_in,
  input  shift_mode_e                       mode_in,
  input  logic [CNT_W-1:0]                  dt_in,
  output logic [CNT_W-1:0]                  cnt,
  output logic [CNT_W-1:0]                  prd_a,
  output logic [CNT_W-1:0]                  half_a,
  output logic [CNT_W-1:0]                  dt_a,
  output logic [NUM_LEGS-1:0][CNT_W-1:0]    leg_off
);
  localparam int EW = CNT_W + 1;

  logic [CNT_W-1:0] prd_c, half_c, lim_c, ipr_c, isr_c, ip_c, is_c, dt_c, oc_off_c, sec_off_c;
  logic [EW-1:0]    mag_c, sum_c, red_c;
  logic             wrap, load;

  // Clamp the shadow inputs against the incoming period
  always_comb begin
    prd_c  = (prd_in < CNT_W'(PRD_MIN)) ? CNT_W'(PRD_MIN) : prd_in;
    half_c = prd_c >> 1;
    lim_c  = (prd_c >> 2) - CNT_W'(1);
    mag_c  = outer_in[CNT_W-1] ? (EW'(0) - {outer_in[CNT_W-1], outer_in}) : {1'b0, outer_in};
    if (mag_c > {1'b0, lim_c}) mag_c = {1'b0, lim_c};
    oc_off_c = (outer_in[CNT_W-1] && (mag_c != '0)) ? (prd_c - mag_c[CNT_W-1:0]) : mag_c[CNT_W-1:0];
    ipr_c  = (inner_pri_in > half_c) ? half_c : inner_pri_in;
    isr_c  = (inner_sec_in > half_c) ? half_c : inner_sec_in;
    unique case (mode_in)
      MODE_SINGLE: begin ip_c = '0;    is_c = '0;    end
      MODE_EXT:    begin ip_c = ipr_c; is_c = '0;    end
      MODE_DUAL:   begin ip_c = ipr_c; is_c = ipr_c; end
      default:     begin ip_c = ipr_c; is_c = isr_c; end
    endcase
    dt_c  = (dt_in >= half_c) ? (half_c - CNT_W'(1)) : dt_in;
    sum_c = {1'b0, oc_off_c} + {1'b0, is_c};
    red_c = sum_c - {1'b0, prd_c};
    sec_off_c = (sum_c >= {1'b0, prd_c}) ? red_c[CNT_W-1:0] : sum_c[CNT_W-1:0];
  end

  assign wrap = (cnt == (prd_a - CNT_W'(1)));
  assign load = !run || wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      prd_a   <= CNT_W'(PRD_MIN);
      half_a  <= CNT_W'(PRD_MIN / 2);
      dt_a    <= '0;
      leg_off <= '0;
    end else begin
      if (!run || wrap) cnt <= '0;
      else              cnt <= cnt + CNT_W'(1);
      if (load) begin
        prd_a      <= prd_c;
        half_a     <= half_c;
        dt_a       <= dt_c;
        leg_off[0] <= '0;
        leg_off[1] <= ip_c;
        leg_off[2] <= oc_off_c;
        leg_off[3] <= sec_off_c;
      end
    end
  end

  assert_cnt_in_range_R1: assert property (@(posedge clk) disable iff (rst)
    cnt < prd_a);
  assert_shadow_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (run && !wrap) |=> ($stable(prd_a) && $stable(dt_a) && $stable(leg_off)));
  assert_period_floor_R6: assert property (@(posedge clk) disable iff (rst)
    prd_a >= CNT_W'(PRD_MIN));
  assert_dead_clamp_R8: assert property (@(posedge clk) disable iff (rst)
    dt_a < half_a);
endmodule

// File: rtl/dab_leg.sv
module dab_leg #(
  parameter int CNT_W  = 12,
  parameter bit INVERT = 1'b0
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] off,
  input  logic [CNT_W-1:0] prd,
  input  logic [CNT_W-1:0] half,
  input  logic [CNT_W-1:0] dt,
  output logic             hi_on,
  output logic             lo_on
);
  logic [CNT_W:0]   diff;
  logic [CNT_W-1:0] pos;
  logic             win_a, win_b;

  always_comb begin
    diff  = {1'b0, cnt} - {1'b0, off};
    pos   = diff[CNT_W] ? (diff[CNT_W-1:0] + prd) : diff[CNT_W-1:0];
    win_a = (pos >= dt) && (pos < half);
    win_b = ({1'b0, pos} >= ({1'b0, half} + {1'b0, dt})) && (pos < prd);
  end

  generate
    if (INVERT) begin : g_inv
      assign hi_on = win_b;
      assign lo_on = win_a;
    end else begin : g_dir
      assign hi_on = win_a;
      assign lo_on = win_b;
    end
  endgenerate
endmodule

// File: rtl/dab_fault.sv
module dab_fault (
  input  logic clk,
  input  logic rst,
  input  logic fault_in,
  input  logic fault_clr,
  output logic latched
);
  always_ff @(posedge clk) begin
    if (rst)            latched <= 1'b0;
    else if (fault_in)  latched <= 1'b1;
    else if (fault_clr) latched <= 1'b0;
  end

  assert_fault_set_R9: assert property (@(posedge clk) disable iff (rst)
    fault_in |=> latched);
  assert_fault_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (latched && !fault_clr) |=> latched);
endmodule

// File: rtl/dab_pwm_gen.sv
module dab_pwm_gen
  import dab_pwm_pkg::*;
#(
  parameter int CNT_W   = 12,
  parameter int PRD_MIN = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic [CNT_W-1:0]        period,
  input  logic signed [CNT_W-1:0] outer_shift,
  input  logic [CNT_W-1:0]        inner_pri,
  input  logic [CNT_W-1:0]        inner_sec,
  input  logic [1:0]              shift_mode,
  input  logic [CNT_W-1:0]        dead_time,
  input  logic                    fault_in,
  input  logic                    fault_clr,
  output logic [NUM_GATES-1:0]    gate,
  output logic                    sync_pulse
);
  logic                           fault_latched, run;
  logic [CNT_W-1:0]               cnt, prd_a, half_a, dt_a;
  logic [NUM_LEGS-1:0][CNT_W-1:0] leg_off;
  logic [NUM_LEGS-1:0]            leg_hi, leg_lo;
  logic [NUM_GATES-1:0]           gate_d, gate_q;
  logic                           sync_q;

  dab_fault u_fault (
    .clk(clk), .rst(rst), .fault_in(fault_in), .fault_clr(fault_clr), .latched(fault_latched)
  );

  assign run = en && !fault_latched && !fault_in;

  dab_timebase #(.CNT_W(CNT_W), .PRD_MIN(PRD_MIN)) u_tb (
    .clk(clk), .rst(rst), .run(run), .prd_in(period), .outer_in(outer_shift),
    .inner_pri_in(inner_pri), .inner_sec_in(inner_sec), .mode_in(shift_mode_e'(shift_mode)),
    .dt_in(dead_time), .cnt(cnt), .prd_a(prd_a), .half_a(half_a), .dt_a(dt_a), .leg_off(leg_off)
  );

  // Legs 0/1 are primary, 2/3 secondary; odd legs carry the mirrored diagonal
  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    dab_leg #(.CNT_W(CNT_W), .INVERT(g % 2 == 1)) u_leg (
      .cnt(cnt), .off(leg_off[g]), .prd(prd_a), .half(half_a), .dt(dt_a),
      .hi_on(leg_hi[g]), .lo_on(leg_lo[g])
    );
    assign gate_d[2*g]   = leg_hi[g];
    assign gate_d[2*g+1] = leg_lo[g];

    assert_no_shoot_through_R4: assert property (@(posedge clk) disable iff (rst)
      !(gate_q[2*g] && gate_q[2*g+1]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q <= '0;
      sync_q <= 1'b0;
    end else begin
      gate_q <= run ? gate_d : '0;
      sync_q <= run && (cnt == '0);
    end
  end

  assign gate       = gate_q;
  assign sync_pulse = sync_q;

  assert_fault_blank_R9: assert property (@(posedge clk) disable iff (rst)
    (fault_in || fault_latched) |=> (gate_q == '0));
  assert_disable_blank_R10: assert property (@(posedge clk) disable iff (rst)
    !en |=> ((gate_q == '0) && !sync_q));
  assert_sync_single_R1: assert property (@(posedge clk) disable iff (rst)
    sync_q |=> !sync_q);
endmodule

// File: tb/dab_pwm_gen_tb_top.sv
module dab_pwm_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 12;
  localparam int PMIN = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic [CW-1:0] period = 12'd1000;
  logic signed [CW-1:0] outer_shift = '0;
  logic [CW-1:0] inner_pri = '0, inner_sec = '0, dead_time = '0;
  logic [1:0] shift_mode = 2'd0;
  logic fault_in = 1'b0, fault_clr = 1'b0;
  logic [7:0] gate;
  logic sync_pulse;

  int checks = 0, errors = 0, cycles = 0;
  int ex_p, ex_oc, ex_ip, ex_is, ex_d;

  always #(CLK_PERIOD/2) clk = ~clk;

  dab_pwm_gen #(.CNT_W(CW), .PRD_MIN(PMIN)) dut_i (
    .clk(clk), .rst(rst), .en(en), .period(period), .outer_shift(outer_shift),
    .inner_pri(inner_pri), .inner_sec(inner_sec), .shift_mode(shift_mode),
    .dead_time(dead_time), .fault_in(fault_in), .fault_clr(fault_clr),
    .gate(gate), .sync_pulse(sync_pulse)
  );

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
      summary();
    end
  end

  task automatic report(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int md(input int v, input int p);
    return ((v % p) + p) % p;
  endfunction

  // Gate pattern from the requirement windows
  function automatic logic [7:0] expg(input int n, input int p, input int oc, input int ip,
                                      input int is, input int d);
    int h, pa, pb, pc, pd;
    logic [7:0] g;
    h  = p / 2;
    pa = md(n, p);
    pb = md(n - ip, p);
    pc = md(n - oc, p);
    pd = md(n - oc - is, p);
    g[0] = (pa >= d && pa < h);   g[1] = (pa >= h + d);
    g[2] = (pb >= h + d);         g[3] = (pb >= d && pb < h);
    g[4] = (pc >= d && pc < h);   g[5] = (pc >= h + d);
    g[6] = (pd >= h + d);         g[7] = (pd >= d && pd < h);
    return g;
  endfunction

  task automatic drive_cfg(input int prd, input int outer, input int ip, input int is,
                           input int mode, input int dt);
    int h, lim, ipr, isr;
    period = CW'(prd); outer_shift = CW'(outer); inner_pri = CW'(ip);
    inner_sec = CW'(is); shift_mode = 2'(mode); dead_time = CW'(dt);
    ex_p = (prd < PMIN) ? PMIN : prd;
    h = ex_p / 2; lim = ex_p / 4 - 1;
    ex_oc = (outer > lim) ? lim : ((outer < -lim) ? -lim : outer);
    ipr = (ip > h) ? h : ip;
    isr = (is > h) ? h : is;
    ex_ip = (mode == 0) ? 0 : ipr;
    ex_is = (mode == 2) ? ipr : ((mode == 3) ? isr : 0);
    ex_d  = (dt >= h) ? h - 1 : dt;
  endtask

  task automatic apply(input int prd, input int outer, input int ip, input int is,
                       input int mode, input int dt);
    @(negedge clk);
    drive_cfg(prd, outer, ip, is, mode, dt);
  endtask

  task automatic wait_sync();
    int t = 0;
    @(negedge clk);
    while (!sync_pulse && t < 5000) begin @(negedge clk); t++; end
  endtask

  // Compare one whole period starting at a sample that shows n=0
  task automatic check_period(input string req, input bit wait_first);
    int bad = 0, bad_n = -1, shoot = 0, spur = 0;
    logic [7:0] e, a_at = '0, e_at = '0;
    if (wait_first) wait_sync();
    report(sync_pulse == 1'b1, req, "sync at period start", sync_pulse, 1);
    for (int n = 0; n < ex_p; n++) begin
      if (n > 0) @(negedge clk);
      e = expg(n, ex_p, ex_oc, ex_ip, ex_is, ex_d);
      if (gate !== e) begin
        if (bad == 0) begin bad_n = n; a_at = gate; e_at = e; end
        bad++;
      end
      if ((gate[0] & gate[1]) | (gate[2] & gate[3]) | (gate[4] & gate[5]) | (gate[6] & gate[7])) shoot++;
      if (n > 0 && sync_pulse) spur++;
    end
    if (bad != 0) $display("  first mismatch at n=%0d", bad_n);
    report(bad == 0, req, "gate pattern", a_at, e_at);
    report(shoot == 0, "R4", "samples with a leg shorted", shoot, 0);
    report(spur == 0, "R1", "extra sync pulses in period", spur, 0);
    @(negedge clk);
    report(sync_pulse == 1'b1, "R1", "sync after P clocks", sync_pulse, 1);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    report(gate == 8'h00 && !sync_pulse, "R10", "outputs in reset", gate, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    report(gate == 8'h00 && !sync_pulse, "R10", "outputs idle while disabled", gate, 0);
  endtask

  task automatic t_single_fwd();
    apply(1000, 100, 0, 0, 0, 10);
    en = 1'b1;
    @(negedge clk);
    report(sync_pulse == 1'b1, "R10", "start at n=0 on enable", sync_pulse, 1);
    check_period("R2", 1'b1);
    check_period("R3", 1'b0);
  endtask

  task automatic t_single_rev();
    apply(1000, -180, 0, 0, 0, 25);
    wait_sync();
    check_period("R3", 1'b1);
  endtask

  task automatic t_modes();
    apply(1000, 120, 150, 0, 1, 15);
    wait_sync();
    check_period("R5", 1'b1);
    apply(1000, 120, 150, 40, 2, 15);
    wait_sync();
    check_period("R5", 1'b1);
    apply(1000, -80, 100, 60, 3, 20);
    wait_sync();
    check_period("R5", 1'b1);
  endtask

  task automatic t_period();
    apply(500, 60, 0, 0, 0, 8);
    wait_sync();
    check_period("R6", 1'b1);
    apply(5, 0, 0, 0, 0, 2);
    wait_sync();
    check_period("R6", 1'b1);
  endtask

  task automatic t_deadtime();
    apply(1000, 100, 0, 0, 0, 150);
    wait_sync();
    check_period("R4", 1'b1);
  endtask

  task automatic t_clamps();
    apply(1000, 400, 700, 0, 1, 900);
    wait_sync();
    check_period("R8", 1'b1);
    apply(1000, -400, 0, 0, 0, 3);
    wait_sync();
    check_period("R8", 1'b1);
  endtask

  task automatic t_shadow();
    int op, ooc, oip, ois, od, bad = 0;
    apply(1000, 100, 0, 0, 0, 10);
    wait_sync();
    check_period("R7", 1'b1);
    op = ex_p; ooc = ex_oc; oip = ex_ip; ois = ex_is; od = ex_d;
    for (int n = 1; n < op; n++) begin
      @(negedge clk);
      if (gate !== expg(n, op, ooc, oip, ois, od)) bad++;
      if (n == 9) drive_cfg(1000, -150, 0, 0, 0, 30);
    end
    report(bad == 0, "R7", "old settings kept after mid-period write", bad, 0);
    @(negedge clk);
    check_period("R7", 1'b0);
  endtask

  task automatic t_fault();
    int lit = 0;
    apply(200, 30, 0, 0, 0, 5);
    wait_sync();
    check_period("R9", 1'b1);
    fault_in = 1'b1;
    @(negedge clk);
    report(gate == 8'h00, "R9", "gates after fault", gate, 0);
    fault_in = 1'b0;
    repeat (20) begin @(negedge clk); if (gate != 0 || sync_pulse) lit++; end
    report(lit == 0, "R9", "samples lit while latched", lit, 0);
    fault_in = 1'b1; fault_clr = 1'b1;
    @(negedge clk);
    fault_in = 1'b0; fault_clr = 1'b0;
    lit = 0;
    repeat (20) begin @(negedge clk); if (gate != 0 || sync_pulse) lit++; end
    report(lit == 0, "R9", "clear ignored while fault high", lit, 0);
    fault_clr = 1'b1;
    @(negedge clk);
    fault_clr = 1'b0;
    report(gate == 8'h00 && !sync_pulse, "R9", "still dark one clock after clear", gate, 0);
    @(negedge clk);
    check_period("R9", 1'b0);
  endtask

  task automatic t_enable();
    int lit = 0;
    @(negedge clk);
    en = 1'b0;
    repeat (30) begin @(negedge clk); if (gate != 0 || sync_pulse) lit++; end
    report(lit == 0, "R10", "samples lit while disabled", lit, 0);
    en = 1'b1;
    @(negedge clk);
    check_period("R10", 1'b0);
  endtask

  initial begin
    t_reset();
    t_single_fwd();
    t_single_rev();
    t_modes();
    t_period();
    t_deadtime();
    t_clamps();
    t_shadow();
    t_fault();
    t_enable();
    summary();
  end
endmodule